// File: doc/BRIEF.md
# Bridge Target Retry Decision Unit

This block sits on the target side of a two-port bus bridge. For every transaction that an initiator starts against the bridge, it decides within one clock whether the bridge takes the transaction now (accept) or makes the initiator come back later (retry). Posted writes are taken whenever the posted-write buffer has room. Reads are handled as delayed transactions. The first attempt is entered into a small queue and retried. Later attempts with the same address and command are retried until the fetched data is ready to hand over, and are then accepted.

Each queue slot holds its address and command and a master-timeout counter. The counter is reloaded when the slot is filled and runs down while the slot's read data waits for the initiator. If the initiator does not return in time, the slot is dropped. A locked sequence in flight filters out unlocked traffic. An acceptance-latency estimate above 16 clocks forces a retry. While old prefetched data is being thrown away, reads are retried. Once a transaction is accepted, its burst is watched, and a disconnect is signalled at the data phase that reaches the last DWORD before an aligned address boundary.

Top module: `brg_tgt_decide`

## Requirements
- R1: Each cycle with `req_vld` high gives exactly one of `rsp_accept` or `rsp_retry`, as a single-cycle pulse in the following cycle. Neither is high after a cycle without `req_vld`.
- R2: While `lock_active` is high, a request with `req_lock` low is retried. A locked request is then decided by the remaining rules.
- R3: A request whose `acc_clks` is greater than 16 is retried. A value of exactly 16 does not by itself cause a retry.
- R4: While `discarding` is high, read requests (`req_write` low) are retried. Writes are not affected.
- R5: A write that passes R2 and R3 is accepted when `pw_free` is at least 2 DWORD slots (one for the address, one for data). Otherwise it is retried. A write never touches the delayed queue.
- R6: A read that passes R2 to R4 and matches no valid slot is stored into the lowest-numbered free slot. `enq_vld` pulses with `enq_idx` giving that slot, together with `rsp_retry`.
- R7: A read that matches no slot while all slots are valid is retried, and nothing is enqueued.
- R8: A read whose address and command both equal a valid slot is retried without enqueue, unless that slot's `rd_avail` bit is high, `rd_head` equals the slot index and `pw_pending` is low.
- R9: When all three R8 conditions hold, the read is accepted and the slot becomes free in the same edge.
- R10: A slot's timeout counter is reloaded on enqueue and counts down by one on each edge where its `rd_avail` bit is high. On the edge where it is already zero with `rd_avail` high and no completion, the slot is freed and its `drop_mask` bit pulses for one cycle.
- R11: After an accept, each `beat_vld` of the open burst is one data phase. The phase whose `beat_dw` is all ones raises `rsp_disc` for one cycle in the following cycle and closes the burst. `beat_last` also closes the burst. Beats outside an open burst are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | A transaction starts this cycle |
| req_addr | input | 32 | Transaction address |
| req_cmd | input | 4 | Bus command |
| req_write | input | 1 | 1 = posted write, 0 = delayed read |
| req_lock | input | 1 | Transaction belongs to a locked sequence |
| lock_active | input | 1 | A locked sequence is crossing the bridge |
| discarding | input | 1 | Stale prefetched read data is being thrown away |
| acc_clks | input | 5 | Estimated clocks needed to accept the transaction |
| pw_free | input | 4 | Free DWORD slots in the posted-write buffer |
| rd_avail | input | 4 | Per slot: fetched read data has arrived |
| rd_head | input | 2 | Slot whose data is at the head of the read-data queue |
| pw_pending | input | 1 | A posted write is queued ahead of returned read data |
| beat_vld | input | 1 | A data phase is taken this cycle |
| beat_last | input | 1 | This data phase ends the burst |
| beat_dw | input | 10 | DWORD index of the phase inside the boundary window |
| rsp_accept | output | 1 | Accept strobe |
| rsp_retry | output | 1 | Retry strobe |
| rsp_disc | output | 1 | Disconnect strobe |
| enq_vld | output | 1 | A read was entered into the delayed queue |
| enq_idx | output | 2 | Slot used by that enqueue |
| drop_mask | output | 4 | Slots freed by master timeout this cycle |

## Verification
A stale valid bit or a wrong stored address shows up on the very next repeat of a read. The read is enqueued when it should be retried, or retried when it should be accepted, and `enq_vld`/`enq_idx` disagree one cycle after the request. A counter that reloads or decrements wrongly moves the `drop_mask` pulse by at least one cycle and also changes whether a later repeat gets R6 or R9. A stuck burst flag shows as a missing or extra `rsp_disc` at the next all-ones beat. The bench therefore compares every output on every cycle against its own model of the slots and the burst.

// File: rtl/brg_tgt_pkg.sv
`timescale 1ns/1ps
package brg_tgt_pkg;
  localparam int ADDR_W = 32;
  localparam int CMD_W  = 4;

  typedef enum logic [1:0] {
    VERD_NONE   = 2'd0,
    VERD_ACCEPT = 2'd1,
    VERD_RETRY  = 2'd2
  } verd_e;
endpackage

// File: rtl/brg_dq_slot.sv
`timescale 1ns/1ps
module brg_dq_slot
  import brg_tgt_pkg::*;
#(
  parameter int TW      = 15,
  parameter int TMO_CYC = (1 << TW) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              done,
  input  logic              rd_avail,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  output logic              vld,
  output logic              hit,
  output logic              expire
);
  logic              vld_q, vld_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic              cnt_en;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;

  // Match and expiry are seen by the decision logic in the same cycle
  assign vld    = vld_q;
  assign hit    = vld_q && (addr_q == req_addr) && (cmd_q == req_cmd);
  assign expire = vld_q && rd_avail && (cnt_q == '0) && !done;

  always_comb begin
    vld_d  = vld_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      vld_d  = 1'b1;
      cnt_d  = TW'(TMO_CYC);
      cnt_en = 1'b1;
    end else if (done || expire) begin
      vld_d = 1'b0;
    end else if (vld_q && rd_avail) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // Payload needs no reset: it is only read while vld_q is set
  always_ff @(posedge clk) begin
    if (load) begin
      addr_q <= req_addr;
      cmd_q  <= req_cmd;
    end
  end
endmodule

// File: rtl/brg_resp_decide.sv
`timescale 1ns/1ps
module brg_resp_decide
  import brg_tgt_pkg::*;
#(
  parameter int N_SLOT    = 4,
  parameter int ACC_W     = 5,
  parameter int ACC_LIMIT = 16,
  parameter int PW_W      = 4,
  parameter int PW_MIN    = 2,
  localparam int IDX_W    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
  input  logic              req_vld,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic              lock_active,
  input  logic              discarding,
  input  logic [ACC_W-1:0]  acc_clks,
  input  logic [PW_W-1:0]   pw_free,
  input  logic [N_SLOT-1:0] slot_vld,
  input  logic [N_SLOT-1:0] slot_hit,
  input  logic [N_SLOT-1:0] rd_avail,
  input  logic [IDX_W-1:0]  rd_head,
  input  logic              pw_pending,
  output verd_e             verd,
  output logic              enq,
  output logic [IDX_W-1:0]  enq_idx,
  output logic [N_SLOT-1:0] slot_load,
  output logic [N_SLOT-1:0] slot_done
);
  logic             hit_any, free_any, done;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             hit_ready;

  // Lowest free slot; the matching slot is unique by construction of enqueue
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    hit_any  = 1'b0;
    hit_idx  = '0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (slot_hit[i]) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  assign hit_ready = rd_avail[hit_idx] && (rd_head == hit_idx) && !pw_pending;

  always_comb begin
    verd    = VERD_NONE;
    enq     = 1'b0;
    enq_idx = '0;
    done    = 1'b0;
    if (req_vld) begin
      if (!req_write && discarding) begin
        verd = VERD_RETRY;
      end else if (lock_active && !req_lock) begin
        verd = VERD_RETRY;
      end else if (acc_clks > ACC_W'(ACC_LIMIT)) begin
        verd = VERD_RETRY;
      end else if (req_write) begin
        verd = (pw_free >= PW_W'(PW_MIN)) ? VERD_ACCEPT : VERD_RETRY;
      end else if (hit_any) begin
        if (hit_ready) begin
          verd = VERD_ACCEPT;
          done = 1'b1;
        end else begin
          verd = VERD_RETRY;
        end
      end else if (free_any) begin
        verd    = VERD_RETRY;
        enq     = 1'b1;
        enq_idx = free_idx;
      end else begin
        verd = VERD_RETRY;
      end
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_dec
    assign slot_load[g] = enq && (enq_idx == IDX_W'(g));
    assign slot_done[g] = done && (hit_idx == IDX_W'(g));
  end
endmodule

// File: rtl/brg_burst_guard.sv
`timescale 1ns/1ps
module brg_burst_guard #(
  parameter int BND_LOG2 = 12,
  localparam int DW_W    = BND_LOG2 - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            open,
  input  logic            beat_vld,
  input  logic            beat_last,
  input  logic [DW_W-1:0] beat_dw,
  output logic            disc
);
  logic open_q, open_d;
  logic disc_q, disc_d;

  always_comb begin
    disc_d = beat_vld && open_q && (&beat_dw);
    open_d = open_q;
    if (open) begin
      open_d = 1'b1;
    end else if (beat_vld && (beat_last || disc_d)) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      open_q <= open_d;
      disc_q <= disc_d;
    end
  end

  assign disc = disc_q;
endmodule

// File: rtl/brg_tgt_decide.sv
`timescale 1ns/1ps
module brg_tgt_decide
  import brg_tgt_pkg::*;
#(
  parameter int N_SLOT    = 4,
  parameter int TW        = 15,
  parameter int TMO_CYC   = (1 << TW) - 1,
  parameter int ACC_W     = 5,
  parameter int ACC_LIMIT = 16,
  parameter int PW_W      = 4,
  parameter int PW_MIN    = 2,
  parameter int BND_LOG2  = 12,
  localparam int IDX_W    = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int DW_W     = BND_LOG2 - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CMD_W-1:0]  req_cmd,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic              lock_active,
  input  logic              discarding,
  input  logic [ACC_W-1:0]  acc_clks,
  input  logic [PW_W-1:0]   pw_free,
  input  logic [N_SLOT-1:0] rd_avail,
  input  logic [IDX_W-1:0]  rd_head,
  input  logic              pw_pending,
  input  logic              beat_vld,
  input  logic              beat_last,
  input  logic [DW_W-1:0]   beat_dw,
  output logic              rsp_accept,
  output logic              rsp_retry,
  output logic              rsp_disc,
  output logic              enq_vld,
  output logic [IDX_W-1:0]  enq_idx,
  output logic [N_SLOT-1:0] drop_mask
);
  logic [N_SLOT-1:0] slot_vld, slot_hit, slot_exp, slot_load, slot_done;
  verd_e             verd;
  logic              enq;
  logic [IDX_W-1:0]  enq_sel;

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    brg_dq_slot #(
      .TW      (TW),
      .TMO_CYC (TMO_CYC)
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (slot_load[g]),
      .done     (slot_done[g]),
      .rd_avail (rd_avail[g]),
      .req_addr (req_addr),
      .req_cmd  (req_cmd),
      .vld      (slot_vld[g]),
      .hit      (slot_hit[g]),
      .expire   (slot_exp[g])
    );
  end

  brg_resp_decide #(
    .N_SLOT    (N_SLOT),
    .ACC_W     (ACC_W),
    .ACC_LIMIT (ACC_LIMIT),
    .PW_W      (PW_W),
    .PW_MIN    (PW_MIN)
  ) decide_i (
    .req_vld     (req_vld),
    .req_write   (req_write),
    .req_lock    (req_lock),
    .lock_active (lock_active),
    .discarding  (discarding),
    .acc_clks    (acc_clks),
    .pw_free     (pw_free),
    .slot_vld    (slot_vld),
    .slot_hit    (slot_hit),
    .rd_avail    (rd_avail),
    .rd_head     (rd_head),
    .pw_pending  (pw_pending),
    .verd        (verd),
    .enq         (enq),
    .enq_idx     (enq_sel),
    .slot_load   (slot_load),
    .slot_done   (slot_done)
  );

  brg_burst_guard #(
    .BND_LOG2 (BND_LOG2)
  ) burst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .open      (verd == VERD_ACCEPT),
    .beat_vld  (beat_vld),
    .beat_last (beat_last),
    .beat_dw   (beat_dw),
    .disc      (rsp_disc)
  );

  // Response strobes: registered, one cycle after the request
  logic              acc_d, ret_d, enq_d;
  logic [IDX_W-1:0]  idx_d;
  logic [N_SLOT-1:0] drop_d;

  always_comb begin
    acc_d  = (verd == VERD_ACCEPT);
    ret_d  = (verd == VERD_RETRY);
    enq_d  = enq;
    idx_d  = enq ? enq_sel : '0;
    drop_d = slot_exp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_accept <= 1'b0;
      rsp_retry  <= 1'b0;
      enq_vld    <= 1'b0;
      enq_idx    <= '0;
      drop_mask  <= '0;
    end else begin
      rsp_accept <= acc_d;
      rsp_retry  <= ret_d;
      enq_vld    <= enq_d;
      enq_idx    <= idx_d;
      drop_mask  <= drop_d;
    end
  end
endmodule

// File: rtl/brg_tgt_decide_chk.sv
`timescale 1ns/1ps
module brg_tgt_decide_chk #(
  parameter int ACC_W     = 5,
  parameter int ACC_LIMIT = 16,
  parameter int PW_W      = 4,
  parameter int PW_MIN    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic             req_write,
  input logic             req_lock,
  input logic             lock_active,
  input logic             discarding,
  input logic [ACC_W-1:0] acc_clks,
  input logic [PW_W-1:0]  pw_free,
  input logic             beat_vld,
  input logic             rsp_accept,
  input logic             rsp_retry,
  input logic             rsp_disc,
  input logic             enq_vld
);
  // R1
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_accept ^ rsp_retry));

  // R1
  no_idle_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !(rsp_accept || rsp_retry));

  // R2
  lock_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && lock_active && !req_lock) |=> rsp_retry);

  // R3
  acc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (int'(acc_clks) > ACC_LIMIT)) |=> rsp_retry);

  // R4
  discard_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_write && discarding) |=> rsp_retry);

  // R5
  pw_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_write && (int'(pw_free) < PW_MIN)) |=> rsp_retry);

  // R6
  enq_with_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enq_vld |-> rsp_retry);

  // R11
  disc_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_disc |-> $past(beat_vld));
endmodule

bind brg_tgt_decide brg_tgt_decide_chk #(
  .ACC_W     (ACC_W),
  .ACC_LIMIT (ACC_LIMIT),
  .PW_W      (PW_W),
  .PW_MIN    (PW_MIN)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_vld     (req_vld),
  .req_write   (req_write),
  .req_lock    (req_lock),
  .lock_active (lock_active),
  .discarding  (discarding),
  .acc_clks    (acc_clks),
  .pw_free     (pw_free),
  .beat_vld    (beat_vld),
  .rsp_accept  (rsp_accept),
  .rsp_retry   (rsp_retry),
  .rsp_disc    (rsp_disc),
  .enq_vld     (enq_vld)
);

// File: tb/brg_tgt_decide_tb_top.sv
`timescale 1ns/1ps
module brg_tgt_decide_tb_top;
  localparam int N   = 4;
  localparam int TMO = 6;
  localparam int BL  = 6;
  localparam int DWW = BL - 2;

  logic clk;
  logic rst_n;
  logic req_vld, req_write, req_lock, lock_active, discarding;
  logic [31:0] req_addr;
  logic [3:0]  req_cmd;
  logic [4:0]  acc_clks;
  logic [3:0]  pw_free;
  logic [N-1:0] rd_avail;
  logic [1:0]  rd_head;
  logic pw_pending, beat_vld, beat_last;
  logic [DWW-1:0] beat_dw;
  logic rsp_accept, rsp_retry, rsp_disc, enq_vld;
  logic [1:0] enq_idx;
  logic [N-1:0] drop_mask;

  brg_tgt_decide #(
    .N_SLOT (N), .TW (15), .TMO_CYC (TMO), .ACC_W (5), .ACC_LIMIT (16),
    .PW_W (4), .PW_MIN (2), .BND_LOG2 (BL)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_addr (req_addr),
    .req_cmd (req_cmd), .req_write (req_write), .req_lock (req_lock),
    .lock_active (lock_active), .discarding (discarding), .acc_clks (acc_clks),
    .pw_free (pw_free), .rd_avail (rd_avail), .rd_head (rd_head),
    .pw_pending (pw_pending), .beat_vld (beat_vld), .beat_last (beat_last),
    .beat_dw (beat_dw), .rsp_accept (rsp_accept), .rsp_retry (rsp_retry),
    .rsp_disc (rsp_disc), .enq_vld (enq_vld), .enq_idx (enq_idx),
    .drop_mask (drop_mask)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // Bench model of the queue and burst
  bit          m_vld[N];
  logic [31:0] m_addr[N];
  logic [3:0]  m_cmd[N];
  int          m_cnt[N];
  bit          m_burst;

  bit e_acc, e_ret, e_enq, e_disc;
  int e_idx;
  logic [N-1:0] e_drop;
  string e_tag;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic predict();
    int hit = -1;
    int free = -1;
    int done = -1;
    e_acc = 0; e_ret = 0; e_enq = 0; e_idx = 0; e_drop = '0; e_disc = 0;
    e_tag = "R1";
    for (int i = 0; i < N; i++)
      if (m_vld[i] && m_addr[i] == req_addr && m_cmd[i] == req_cmd) hit = i;
    for (int i = N - 1; i >= 0; i--)
      if (!m_vld[i]) free = i;
    if (req_vld) begin
      if (!req_write && discarding) begin e_ret = 1; e_tag = "R4"; end
      else if (lock_active && !req_lock) begin e_ret = 1; e_tag = "R2"; end
      else if (int'(acc_clks) > 16) begin e_ret = 1; e_tag = "R3"; end
      else if (req_write) begin
        e_tag = "R5";
        if (int'(pw_free) >= 2) e_acc = 1; else e_ret = 1;
      end else if (hit >= 0) begin
        if (rd_avail[hit] && int'(rd_head) == hit && !pw_pending) begin
          e_acc = 1; e_tag = "R9"; done = hit;
        end else begin
          e_ret = 1; e_tag = "R8";
        end
      end else if (free < 0) begin e_ret = 1; e_tag = "R7"; end
      else begin e_ret = 1; e_enq = 1; e_idx = free; e_tag = "R6"; end
    end
    if (beat_vld && m_burst && (&beat_dw)) e_disc = 1;
    if (e_acc) m_burst = 1;
    else if (beat_vld && (beat_last || e_disc)) m_burst = 0;
    for (int i = 0; i < N; i++) begin
      if (m_vld[i]) begin
        if (i == done) m_vld[i] = 0;
        else if (rd_avail[i]) begin
          if (m_cnt[i] == 0) begin e_drop[i] = 1'b1; m_vld[i] = 0; end
          else m_cnt[i]--;
        end
      end
    end
    if (e_enq) begin
      m_vld[e_idx] = 1; m_addr[e_idx] = req_addr; m_cmd[e_idx] = req_cmd;
      m_cnt[e_idx] = TMO;
    end
  endtask

  task automatic step();
    predict();
    @(negedge clk);
    chk(e_tag, "accept", int'(rsp_accept), int'(e_acc));
    chk(e_tag, "retry", int'(rsp_retry), int'(e_ret));
    chk(e_tag, "enq_vld", int'(enq_vld), int'(e_enq));
    if (e_enq) chk("R6", "enq_idx", int'(enq_idx), e_idx);
    chk("R10", "drop_mask", int'(drop_mask), int'(e_drop));
    chk("R11", "disconnect", int'(rsp_disc), int'(e_disc));
  endtask

  task automatic rq(logic [31:0] a, logic [3:0] c, logic w, logic l);
    req_vld = 1; req_addr = a; req_cmd = c; req_write = w; req_lock = l;
    step();
    req_vld = 0;
  endtask

  task automatic beat(int dw, logic last);
    beat_vld = 1; beat_dw = DWW'(dw); beat_last = last;
    step();
    beat_vld = 0; beat_last = 0;
  endtask

  initial begin
    rst_n = 0; req_vld = 0; req_addr = '0; req_cmd = '0; req_write = 0;
    req_lock = 0; lock_active = 0; discarding = 0; acc_clks = 5'd2;
    pw_free = 4'd8; rd_avail = '0; rd_head = '0; pw_pending = 0;
    beat_vld = 0; beat_last = 0; beat_dw = '0;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_cnt[i] = 0; end
    m_burst = 0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset accept", int'(rsp_accept), 0);
    chk("R1", "reset retry", int'(rsp_retry), 0);
    chk("R6", "reset enq", int'(enq_vld), 0);
    chk("R10", "reset drop", int'(drop_mask), 0);

    // R6 fill all slots, R7 overflow
    for (int k = 0; k < 4; k++) rq(32'h100 + 32'(k * 4), 4'h6, 0, 0);
    rq(32'h200, 4'h6, 0, 0);
    // R8 repeat not ready, wrong head, pending write
    rq(32'h100, 4'h6, 0, 0);
    rd_avail = 4'b0001; rd_head = 2'd1;
    rq(32'h100, 4'h6, 0, 0);
    rd_head = 2'd0; pw_pending = 1;
    rq(32'h100, 4'h6, 0, 0);
    // R8 same address, other command is no match while full -> R7
    pw_pending = 0;
    rq(32'h100, 4'h7, 0, 0);
    // R9 complete
    rq(32'h100, 4'h6, 0, 0);
    rd_avail = '0;
    // R11 burst boundary
    beat(14, 0);
    beat(15, 0);
    beat(15, 0);
    // R6 reuse lowest free slot
    rq(32'h200, 4'h6, 0, 0);
    // R10 timeout on slot 1
    rd_avail = 4'b0010;
    repeat (10) step();
    rd_avail = '0;
    rq(32'h104, 4'h6, 0, 0);
    // R5 posted-write room
    pw_free = 4'd1; rq(32'h300, 4'h7, 1, 0);
    pw_free = 4'd2; rq(32'h300, 4'h7, 1, 0);
    beat(3, 1);
    // R2 lock filter
    lock_active = 1;
    rq(32'h400, 4'h6, 0, 0);
    rq(32'h300, 4'h7, 1, 1);
    lock_active = 0;
    // R3 acceptance limit
    acc_clks = 5'd17; rq(32'h300, 4'h7, 1, 0);
    acc_clks = 5'd16; rq(32'h300, 4'h7, 1, 0);
    acc_clks = 5'd2;
    // R4 discard in progress
    discarding = 1;
    rq(32'h500, 4'h6, 0, 0);
    rq(32'h300, 4'h7, 1, 0);
    discarding = 0;

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      req_vld     = ($urandom % 3) == 0;
      req_addr    = 32'h1000 + 32'(($urandom % 6) * 4);
      req_cmd     = (($urandom % 2) == 0) ? 4'h6 : 4'hE;
      req_write   = ($urandom % 10) < 3;
      req_lock    = ($urandom % 10) == 0;
      lock_active = ($urandom % 10) == 0;
      discarding  = ($urandom % 10) == 0;
      acc_clks    = 5'($urandom % 21);
      pw_free     = 4'($urandom % 8);
      if (($urandom % 4) == 0) rd_avail = 4'($urandom);
      rd_head     = 2'($urandom);
      pw_pending  = ($urandom % 5) == 0;
      beat_vld    = ($urandom % 2) == 0;
      beat_dw     = DWW'(12 + ($urandom % 4));
      beat_last   = ($urandom % 10) == 0;
      step();
    end
    req_vld = 0; beat_vld = 0;
    step();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule